// File: doc/BRIEF.md
# Incremental Quadrature Output Generator

This block turns a 12-bit absolute angle sample, refreshed every clock, into the A, B and once-per-turn index (Ri) signals of an incremental encoder. A zero-offset register defines where the turn begins. The register is loaded in one of two ways: a rising edge on a zero input captures the present angle, or a direct register write stores any value. The angle minus this offset is the relative position. A sign control can invert the relative position, and a programmable hysteresis filter then removes small reversals.

The filtered position is cut down to the selected number of counts per turn by dropping low-order bits. An internal output counter walks toward this target one count per clock, always along the shorter way around the turn. The low two bits of the counter become a Gray-coded A/B pair. Ri marks count zero. An output-disable control forces the three pins low while tracking continues underneath.

Top module: `qgen_incr_out`

## Requirements
- R1: The relative position is (angle_i - zero register) modulo 4096, and the counter settles on the count this implies.
- R2: A low-to-high change of zero_pin_i loads the current angle_i into the zero register. Keeping the pin high does not cause another capture.
- R3: A write (zero_wr_i high) loads zero_wdata_i into the zero register. When a write and a pin edge occur in the same cycle, the write wins.
- R4: res_sel_i = k selects 4096 >> k counts per turn (k = 0 gives 4096, k = 7 gives 32). The target count is the filtered position shifted right by k.
- R5: For a count c, {qa_o,qb_o} = {c[1], c[1]^c[0]}. Rising counts therefore give 00, 01, 11, 10, so B leads A. With sign_i = 0, a rising angle only ever moves the count forward.
- R6: sign_i = 1 uses the negated relative position, so a rising angle moves the count backward.
- R7: ri_o is high exactly while the count is 0, which is one quarter of an A/B period in the state where A = B = 0.
- R8: With hysteresis value H (0..127), a change against the last accepted direction is taken only if its size exceeds H. A change in the same direction is always taken. The direction after reset is forward, and a change of exactly half a turn counts as backward.
- R9: out_dis_i = 1 drives qa_o, qb_o and ri_o low from the next clock on. The count keeps tracking, and the pins show it again once the disable is removed.
- R10: The count changes by at most one per clock. When the target is exactly half a turn away it steps backward; otherwise it steps the shorter way.
- R11: After reset the zero register and the count are 0, so with outputs enabled qa_o = qb_o = 0 and ri_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| angle_i | input | 12 | Absolute angle sample |
| zero_pin_i | input | 1 | Zero capture input, acts on its rising edge |
| zero_wr_i | input | 1 | Direct zero register write strobe |
| zero_wdata_i | input | 12 | Value for a direct zero write |
| res_sel_i | input | 3 | Counts-per-turn code |
| hyst_i | input | 7 | Hysteresis in 12-bit LSB units |
| sign_i | input | 1 | 0 forward, 1 reversed counting |
| out_dis_i | input | 1 | 1 forces the outputs low |
| qa_o | output | 1 | Quadrature A |
| qb_o | output | 1 | Quadrature B |
| ri_o | output | 1 | Once-per-turn index |

## Verification
The bench sweeps every counts-per-turn code with an angle step that is not a power of two, so truncation that dropped the wrong bits would end on the wrong A/B state or index. It decodes each A/B transition into a running count. This catches any double step and any wrong lead/lag, and it also catches a sign control that failed to reverse the direction. Jumps of just under and exactly half a turn check the tie-break and the one-count-per-clock rate. Hysteresis sequences near the threshold expose an off-by-one comparison. Zero capture is tested with the pin held high and with a simultaneous write, which exposes level-sensitive capture and wrong priority.

// File: rtl/qgen_pkg.sv
package qgen_pkg;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_BWD = 1'b1
   } qdir_e;

   // two-bit count to {A,B}; forward order 00,01,11,10 (B leads)
   function automatic logic [1:0] cnt_to_ab(input logic [1:0] c);
      return {c[1], c[1] ^ c[0]};
   endfunction

endpackage

// File: rtl/qgen_zero_reg.sv
module qgen_zero_reg #(
   parameter int ANG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ANG_W-1:0] angle_i,
   input  logic             zero_pin_i,
   input  logic             zero_wr_i,
   input  logic [ANG_W-1:0] zero_wdata_i,
   output logic [ANG_W-1:0] zero_o
);

   logic             pin_q;
   logic [ANG_W-1:0] zero_q;
   logic             pin_edge;

   assign pin_edge = zero_pin_i & ~pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         zero_q <= '0;
      end else begin
         pin_q <= zero_pin_i;
         if (zero_wr_i)
            zero_q <= zero_wdata_i;
         else if (pin_edge)
            zero_q <= angle_i;
      end
   end

   assign zero_o = zero_q;

endmodule

// File: rtl/qgen_hyst.sv
module qgen_hyst
   import qgen_pkg::*;
#(
   parameter int ANG_W   = 12,
   parameter int HYST_W  = 7,
   parameter bit HYST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ANG_W-1:0]  angle_i,
   input  logic [ANG_W-1:0]  zero_i,
   input  logic              sign_i,
   input  logic [HYST_W-1:0] hyst_i,
   output logic [ANG_W-1:0]  pos_o
);

   logic [ANG_W-1:0] rel;
   logic [ANG_W-1:0] signed_pos;
   logic [ANG_W-1:0] pos_q;

   assign rel        = angle_i - zero_i;
   assign signed_pos = sign_i ? (ANG_W'(0) - rel) : rel;

   generate
      if (HYST_EN) begin : g_hyst
         qdir_e            dir_q;
         logic [ANG_W-1:0] delta;
         logic [ANG_W-1:0] back_mag;
         logic             move_fwd;
         logic             move_bwd;
         logic             over_fwd;
         logic             over_bwd;
         logic             take;

         always_comb begin
            delta    = signed_pos - pos_q;
            move_fwd = (delta != '0) && !delta[ANG_W-1];
            move_bwd = delta[ANG_W-1];
            back_mag = ANG_W'(0) - delta;
            over_fwd = delta > ANG_W'(hyst_i);
            over_bwd = back_mag > ANG_W'(hyst_i);
            if (dir_q == DIR_FWD)
               take = move_fwd || (move_bwd && over_bwd);
            else
               take = move_bwd || (move_fwd && over_fwd);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pos_q <= '0;
               dir_q <= DIR_FWD;
            end else if (take) begin
               pos_q <= signed_pos;
               dir_q <= move_fwd ? DIR_FWD : DIR_BWD;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               pos_q <= '0;
            else
               pos_q <= signed_pos;
         end
      end
   endgenerate

   assign pos_o = pos_q;

endmodule

// File: rtl/qgen_stepper.sv
module qgen_stepper #(
   parameter int ANG_W = 12,
   parameter int RES_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ANG_W-1:0] pos_i,
   input  logic [RES_W-1:0] res_i,
   output logic [ANG_W-1:0] cnt_o
);

   localparam logic [ANG_W-1:0] ALL_ONES = {ANG_W{1'b1}};
   localparam logic [ANG_W-1:0] TOP_BIT  = {1'b1, {(ANG_W-1){1'b0}}};

   logic [ANG_W-1:0] cnt_q;
   logic [ANG_W-1:0] mask;
   logic [ANG_W-1:0] half;
   logic [ANG_W-1:0] target;
   logic [ANG_W-1:0] gap;
   logic [ANG_W-1:0] cnt_m;

   always_comb begin
      mask   = ALL_ONES >> res_i;
      half   = TOP_BIT >> res_i;
      target = pos_i >> res_i;
      cnt_m  = cnt_q & mask;
      gap    = (target - cnt_m) & mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (gap != '0) begin
         if ((gap & half) != '0)
            cnt_q <= (cnt_m - ANG_W'(1)) & mask;
         else
            cnt_q <= (cnt_m + ANG_W'(1)) & mask;
      end
   end

   assign cnt_o = cnt_m;

endmodule

// File: rtl/qgen_incr_out.sv
module qgen_incr_out
   import qgen_pkg::*;
#(
   parameter int ANG_W   = 12,
   parameter int RES_W   = 3,
   parameter int HYST_W  = 7,
   parameter bit HYST_EN = 1'b1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ANG_W-1:0]  angle_i,
   input  logic              zero_pin_i,
   input  logic              zero_wr_i,
   input  logic [ANG_W-1:0]  zero_wdata_i,
   input  logic [RES_W-1:0]  res_sel_i,
   input  logic [HYST_W-1:0] hyst_i,
   input  logic              sign_i,
   input  logic              out_dis_i,
   output logic              qa_o,
   output logic              qb_o,
   output logic              ri_o
);

   localparam int MAX_SHIFT = (1 << RES_W) - 1;

   generate
      if (MAX_SHIFT > ANG_W - 2) begin : g_bad_res
         $error("qgen_incr_out: RES_W too wide for ANG_W");
      end
      if (HYST_W >= ANG_W) begin : g_bad_hyst
         $error("qgen_incr_out: HYST_W must be below ANG_W");
      end
   endgenerate

   logic [ANG_W-1:0] zero_q;
   logic [ANG_W-1:0] pos_q;
   logic [ANG_W-1:0] cnt_q;
   logic [1:0]       ab_n;
   logic             ri_n;

   qgen_zero_reg #(.ANG_W(ANG_W)) u_zero (
      .clk          (clk),
      .rst_n        (rst_n),
      .angle_i      (angle_i),
      .zero_pin_i   (zero_pin_i),
      .zero_wr_i    (zero_wr_i),
      .zero_wdata_i (zero_wdata_i),
      .zero_o       (zero_q)
   );

   qgen_hyst #(.ANG_W(ANG_W), .HYST_W(HYST_W), .HYST_EN(HYST_EN)) u_hyst (
      .clk     (clk),
      .rst_n   (rst_n),
      .angle_i (angle_i),
      .zero_i  (zero_q),
      .sign_i  (sign_i),
      .hyst_i  (hyst_i),
      .pos_o   (pos_q)
   );

   qgen_stepper #(.ANG_W(ANG_W), .RES_W(RES_W)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .pos_i (pos_q),
      .res_i (res_sel_i),
      .cnt_o (cnt_q)
   );

   always_comb begin
      ab_n = cnt_to_ab(cnt_q[1:0]);
      ri_n = (cnt_q == '0);
      if (out_dis_i) begin
         ab_n = 2'b00;
         ri_n = 1'b0;
      end
   end

   generate
      if (OUT_REG) begin : g_oreg
         logic qa_q, qb_q, ri_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               qa_q <= 1'b0;
               qb_q <= 1'b0;
               ri_q <= 1'b0;
            end else begin
               qa_q <= ab_n[1];
               qb_q <= ab_n[0];
               ri_q <= ri_n;
            end
         end
         assign qa_o = qa_q;
         assign qb_o = qb_q;
         assign ri_o = ri_q;
      end else begin : g_ocomb
         assign qa_o = ab_n[1];
         assign qb_o = ab_n[0];
         assign ri_o = ri_n;
      end
   endgenerate

endmodule

// File: rtl/qgen_chk.sv
module qgen_chk #(
   parameter int ANG_W = 12,
   parameter int RES_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ANG_W-1:0] angle_i,
   input logic             zero_pin_i,
   input logic             zero_wr_i,
   input logic [ANG_W-1:0] zero_wdata_i,
   input logic [RES_W-1:0] res_sel_i,
   input logic             out_dis_i,
   input logic             qa_o,
   input logic             qb_o,
   input logic             ri_o,
   input logic [ANG_W-1:0] zero_q,
   input logic [ANG_W-1:0] cnt_q
);

   logic [ANG_W-1:0] mask_w;
   assign mask_w = {ANG_W{1'b1}} >> res_sel_i;

   // R3: a write lands in the zero register on the next cycle
   assert_wr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      zero_wr_i |=> (zero_q == $past(zero_wdata_i)));

   // R2: pin rising edge captures the angle when no write competes
   assert_pin_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(zero_pin_i) && !zero_wr_i) |=> (zero_q == $past(angle_i)));

   // R10: at most one count per clock
   assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(res_sel_i) |->
         ((((cnt_q - $past(cnt_q)) & mask_w) == '0) ||
          (((cnt_q - $past(cnt_q)) & mask_w) == ANG_W'(1)) ||
          (((cnt_q - $past(cnt_q)) & mask_w) == mask_w)));

   // R5: A and B never toggle together while enabled
   assert_ab_gray_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_dis_i && !$past(out_dis_i) && !$past(out_dis_i, 2)) |->
         !((qa_o != $past(qa_o)) && (qb_o != $past(qb_o))));

   // R7: index only in the A=B=0 state
   assert_ri_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ri_o |-> (!qa_o && !qb_o));

   // R9: outputs low during a held disable
   assert_dis_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_dis_i && $past(out_dis_i)) |-> (!qa_o && !qb_o && !ri_o));

endmodule

bind qgen_incr_out qgen_chk #(.ANG_W(ANG_W), .RES_W(RES_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .angle_i      (angle_i),
   .zero_pin_i   (zero_pin_i),
   .zero_wr_i    (zero_wr_i),
   .zero_wdata_i (zero_wdata_i),
   .res_sel_i    (res_sel_i),
   .out_dis_i    (out_dis_i),
   .qa_o         (qa_o),
   .qb_o         (qb_o),
   .ri_o         (ri_o),
   .zero_q       (zero_q),
   .cnt_q        (cnt_q)
);

// File: tb/qgen_incr_out_bench.sv
`timescale 1ns/1ps
module qgen_incr_out_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] ang = '0;
   logic        zpin = 1'b0;
   logic        zwr = 1'b0;
   logic [11:0] zdat = '0;
   logic [2:0]  res = '0;
   logic [6:0]  hy = '0;
   logic        sgn = 1'b0;
   logic        dis = 1'b0;
   logic        qa, qb, qri;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model
   int  zero_m = 0;
   int  held_m = 0;
   bit  dir_m = 0;

   // monitor state
   int       pos_tb = 0;
   int       fwd_n = 0;
   int       bwd_n = 0;
   bit       mon_en = 1;
   bit       resync_req = 0;
   int       resync_val = 0;
   logic [1:0] prev_ab = 2'b00;

   always #5 clk = ~clk;

   qgen_incr_out u_qgen_incr_out (
      .clk(clk), .rst_n(rst_n), .angle_i(ang), .zero_pin_i(zpin),
      .zero_wr_i(zwr), .zero_wdata_i(zdat), .res_sel_i(res), .hyst_i(hy),
      .sign_i(sgn), .out_dis_i(dis), .qa_o(qa), .qb_o(qb), .ri_o(qri)
   );

   function automatic logic [1:0] nxt(input logic [1:0] s);
      case (s)
         2'b00: return 2'b01;
         2'b01: return 2'b11;
         2'b11: return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [1:0] ab_of(input int c);
      return {c[1], c[1] ^ c[0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // decode every A/B change into a running count
   always @(negedge clk) begin
      logic [1:0] cur;
      cur = {qa, qb};
      if (!rst_n) begin
         pos_tb = 0; fwd_n = 0; bwd_n = 0; prev_ab = 2'b00;
      end else if (resync_req) begin
         prev_ab = cur; pos_tb = resync_val; resync_req = 0;
      end else if (mon_en && cur != prev_ab) begin
         if (cur == nxt(prev_ab)) begin pos_tb++; fwd_n++; end
         else if (prev_ab == nxt(cur)) begin pos_tb--; bwd_n--; bwd_n += 2; end
         else chk(0, "R10 double step", cur, nxt(prev_ab));
         prev_ab = cur;
      end else prev_ab = cur;
   end

   task automatic model_apply();
      int rel, s, d, mag;
      bit fwd, acc;
      rel = (ang - zero_m) & 4095;
      s = sgn ? ((0 - rel) & 4095) : rel;
      d = (s - held_m) & 4095;
      if (d != 0) begin
         fwd = (d < 2048);
         mag = 4096 - d;
         if (!dir_m) acc = fwd || (mag > hy);
         else        acc = !fwd || (d > hy);
         if (acc) begin held_m = s; dir_m = !fwd; end
      end
   endtask

   task automatic step_in();
      @(posedge clk); #2;
   endtask

   task automatic set_ang(input int a);
      step_in(); ang = a[11:0]; model_apply();
   endtask

   task automatic wr_zero(input int v);
      step_in(); zwr = 1; zdat = v[11:0]; zero_m = v & 4095; model_apply();
      step_in(); zwr = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk); #3;
   endtask

   task automatic check_state(input string tag);
      int t, m;
      t = held_m >> res;
      m = (4096 >> res) - 1;
      chk((pos_tb & m) == t, {tag, " count"}, pos_tb & m, t);
      chk({qa, qb} == ab_of(t), {tag, " ab"}, {qa, qb}, ab_of(t));
      chk(qri == (t == 0), {tag, " ri"}, qri, (t == 0));
   endtask

   task automatic do_reset(input int r, input bit s, input int h);
      @(posedge clk); #2;
      rst_n = 0; ang = 0; zpin = 0; zwr = 0; zdat = 0; dis = 0;
      res = r[2:0]; sgn = s; hy = h[6:0]; mon_en = 1;
      zero_m = 0; held_m = 0; dir_m = 0;
      repeat (3) @(posedge clk); #2;
      rst_n = 1; model_apply();
   endtask

   task automatic sweep(input int k, input bit s);
      int f0, b0;
      do_reset(k, s, 0);
      wr_zero(1000);
      settle(1010);
      check_state($sformatf("R1 zero-offset res%0d", k));
      f0 = fwd_n; b0 = bwd_n;
      for (int i = 1; i < 64; i++) begin
         set_ang(i * 67);
         settle((67 >> k) + 8);
         check_state($sformatf("R4 R7 sweep res%0d sign%0d step%0d", k, s, i));
      end
      if (!s) chk(bwd_n == b0, "R5 forward only", bwd_n - b0, 0);
      else    chk(fwd_n == f0, "R6 reversed only", fwd_n - f0, 0);
   endtask

   initial begin
      // R11 reset state
      do_reset(0, 0, 0);
      settle(4);
      chk(qa == 0 && qb == 0, "R11 reset ab", {qa, qb}, 0);
      chk(qri == 1, "R11 reset ri", qri, 1);

      for (int k = 0; k < 8; k++) sweep(k, 0);
      sweep(2, 1);
      sweep(0, 1);

      // R2 / R3 zero register
      do_reset(0, 0, 0);
      set_ang(1234); settle(1245);
      check_state("R1 pre-zero");
      step_in(); zpin = 1; zero_m = 1234; model_apply();
      settle(1245);
      chk(qri == 1, "R2 capture gives index", qri, 1);
      check_state("R2 capture");
      set_ang(1300); settle(80);
      check_state("R2 held pin no recapture");
      step_in(); zpin = 0;
      step_in(); zpin = 1; zwr = 1; zdat = 500; zero_m = 500; model_apply();
      step_in(); zwr = 0;
      settle(760);
      check_state("R3 write beats pin edge");

      // R8 hysteresis
      do_reset(0, 0, 10);
      set_ang(100); settle(110); check_state("R8 fwd 100");
      set_ang(95);  settle(20);  check_state("R8 small reversal ignored");
      chk(held_m == 100, "R8 model hold", held_m, 100);
      set_ang(89);  settle(30);  check_state("R8 reversal of 11 taken");
      set_ang(92);  settle(20);  check_state("R8 reversal of 3 ignored");
      set_ang(100); settle(30);  check_state("R8 reversal of 11 taken fwd");
      set_ang(110); settle(30);  check_state("R8 same direction taken");

      // R9 disable
      do_reset(3, 0, 0);
      set_ang(800); settle(120); check_state("R9 pre-disable");
      step_in(); mon_en = 0; dis = 1;
      settle(3);
      chk({qa, qb, qri} == 3'b000, "R9 outputs low", {qa, qb, qri}, 0);
      set_ang(800 + 37 * 8); settle(60);
      chk({qa, qb, qri} == 3'b000, "R9 still low", {qa, qb, qri}, 0);
      step_in(); dis = 0;
      settle(3);
      begin
         int t;
         t = held_m >> res;
         chk({qa, qb} == ab_of(t), "R9 tracked while off", {qa, qb}, ab_of(t));
         resync_val = t; resync_req = 1; mon_en = 1;
      end
      settle(3);

      // R10 rate and tie-break
      do_reset(0, 0, 0);
      set_ang(2047);
      settle(1000);
      chk(fwd_n <= 1001 && fwd_n > 0, "R10 rate limited", fwd_n, 1000);
      settle(1100);
      chk(fwd_n == 2047 && bwd_n == 0, "R10 short way fwd", fwd_n, 2047);
      check_state("R10 arrive 2047");
      set_ang(4095);
      settle(2100);
      chk(bwd_n == 2048, "R10 half turn goes backward", bwd_n, 2048);
      check_state("R10 arrive 4095");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1900000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule